// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave Engine

This block is the slave side of a serial memory that is reached over a four-wire SPI link with an added pause input. A chip-side system clock oversamples the select, serial clock, serial data and pause pins. The engine decodes an 8-bit command and takes a 16-bit byte address. It then streams bytes out of an internal array, or it collects one byte for the array or for the status register. The serial output comes with a separate enable, so the pad can be tristated.

A programming command first arms a write-enable latch. The write happens when select is released after a complete sequence. After that the engine stays busy for a programmable number of system clocks. While busy, it answers only the status command, and that command returns all ones. When the busy period ends, the write-enable latch clears itself.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the output enable is low and the status byte reads 0x00.
- R2: Opcodes are decoded with bit 3 ignored: 0x06/0x0E arm the write-enable latch (status bit 1 set). Any opcode whose upper nibble is nonzero, such as 0x16 or 0x8C, leaves the latch unchanged.
- R3: Data leaves MSB first. It changes only after a falling serial clock edge and input is sampled on the rising edge, so both clock-idle-low and clock-idle-high framing read identically. The status byte is {protect-enable bit 7, 0, 0, 0, level bits 3:2, write-enable bit 1, busy bit 0}.
- R4: Read (0x03) streams from the address onward, incrementing after each byte. The address wraps from the highest address (0x7FF with defaults) to 0, and address bits above ADDR_W are ignored.
- R5: Write (0x02) stores exactly the first complete data byte, and only when select rises. Later bytes are ignored, and a sequence released before a full data byte writes nothing and starts no busy period.
- R6: Write and status-write sequences issued while the write-enable latch is clear change nothing.
- R7: After an invalid opcode the output stays disabled for the rest of that selection. The next selection decodes normally.
- R8: While select is high the output enable is low.
- R9: Pulling the pause input low while the serial clock is low disables the output and ignores serial clock edges. Raising it while the clock is low resumes the transfer where it stopped.
- R10: A write holds the engine busy for BUSY_CYC clocks. During that time status reads 0xFF and every other opcode is refused with the output disabled. At the end the write-enable latch is clear.
- R11: Opcode 0x04/0x0C clears the write-enable latch.
- R12: Status write (0x01) stores only bits 7, 3 and 2 of its data byte, and the other status bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data into the engine |
| hold_n_i | input | 1 | Active-low transfer pause |
| so_o | output | 1 | Serial data out of the engine |
| so_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
A corrupted sequencer state shows up as a wrong byte, or as the output enable being wrong, within the next byte time on the serial pins. A lost or spurious write-enable latch shows in the status byte on the very next status read. It also shows as an array byte that differs from what was stored, or as a write that stays missing. A busy counter that is wrong makes the 0xFF status and the refused reads last too long or too short. The resulting gap shows within one read after the expected end of the busy period.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR_HI, S_ADDR_LO,
        S_RD_DATA, S_WR_DATA, S_ST_RD, S_ST_WR, S_IGNORE
    } seq_e;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_ARRAY, PEND_STATUS
    } pend_e;

    localparam logic [7:0] OP_MASK  = 8'hF7;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[addr_i] <= wdata_i;
    end

    assign rdata_o = cells[addr_i];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int BUSY_CYC = 1000,
    localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    input  logic hold_n_i,
    output logic so_o,
    output logic so_oe_o
);
    typedef struct packed {
        seq_e              st;
        pend_e             pend;
        logic [2:0]        bitcnt;
        logic [6:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic              is_wr;
        logic              load;
        logic [7:0]        out_sh;
        logic              so;
        logic              paused;
        logic [7:0]        pend_data;
        logic              wel;
        logic [1:0]        bp;
        logic              wpen;
        logic [CNT_W-1:0]  busy_cnt;
        logic              sck_p;
        logic              cs_p;
        logic              hold_p;
    } eng_t;

    eng_t eng_q, eng_d;

    logic cs_s, sck_s, si_s, hold_s;
    logic sck_rise, sck_fall, cs_rise, cs_fall, hold_fall, hold_rise;
    logic busy, mem_we, paused, wel;
    logic [7:0] rdata, byte_in, op, stat;

    spi_mem_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n_i, sck_i, si_i, hold_n_i}),
        .sync_o ({cs_s, sck_s, si_s, hold_s})
    );

    spi_mem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .we_i   (mem_we),
        .addr_i (eng_q.addr),
        .wdata_i(eng_q.pend_data),
        .rdata_o(rdata)
    );

    assign sck_rise  = sck_s & ~eng_q.sck_p;
    assign sck_fall  = ~sck_s & eng_q.sck_p;
    assign cs_rise   = cs_s & ~eng_q.cs_p;
    assign cs_fall   = ~cs_s & eng_q.cs_p;
    assign hold_fall = ~hold_s & eng_q.hold_p;
    assign hold_rise = hold_s & ~eng_q.hold_p;
    assign busy      = (eng_q.busy_cnt != '0);
    assign paused    = eng_q.paused;
    assign wel       = eng_q.wel;

    always_comb begin
        eng_d        = eng_q;
        mem_we       = 1'b0;
        eng_d.sck_p  = sck_s;
        eng_d.cs_p   = cs_s;
        eng_d.hold_p = hold_s;
        byte_in      = {eng_q.sh, si_s};
        op           = byte_in & OP_MASK;
        stat         = busy ? 8'hFF : {eng_q.wpen, 3'b000, eng_q.bp, eng_q.wel, 1'b0};

        if (busy) begin
            if (eng_q.busy_cnt == CNT_W'(1)) eng_d.wel = 1'b0;
            eng_d.busy_cnt = eng_q.busy_cnt - CNT_W'(1);
        end

        if (cs_s) begin
            if (cs_rise) begin
                case (eng_q.pend)
                    PEND_ARRAY: begin
                        mem_we         = 1'b1;
                        eng_d.busy_cnt = CNT_W'(BUSY_CYC);
                    end
                    PEND_STATUS: begin
                        eng_d.wpen     = eng_q.pend_data[7];
                        eng_d.bp       = eng_q.pend_data[3:2];
                        eng_d.busy_cnt = CNT_W'(BUSY_CYC);
                    end
                    default: ;
                endcase
            end
            eng_d.st     = S_IDLE;
            eng_d.pend   = PEND_NONE;
            eng_d.paused = 1'b0;
            eng_d.load   = 1'b0;
        end else if (cs_fall) begin
            eng_d.st     = S_CMD;
            eng_d.bitcnt = '0;
            eng_d.pend   = PEND_NONE;
            eng_d.paused = 1'b0;
        end else begin
            if (eng_q.load) begin
                eng_d.load = 1'b0;
                if (eng_q.st == S_ST_RD) begin
                    eng_d.out_sh = stat;
                end else begin
                    eng_d.out_sh = rdata;
                    eng_d.addr   = eng_q.addr + ADDR_W'(1);
                end
            end
            if (!eng_q.paused && hold_fall && !sck_s) eng_d.paused = 1'b1;
            if (eng_q.paused && hold_rise && !sck_s)  eng_d.paused = 1'b0;

            if (!eng_q.paused && sck_rise && eng_q.st != S_IGNORE && eng_q.st != S_IDLE) begin
                eng_d.sh     = byte_in[6:0];
                eng_d.bitcnt = eng_q.bitcnt + 3'd1;
                if (eng_q.st == S_ADDR_HI || eng_q.st == S_ADDR_LO)
                    eng_d.addr = {eng_q.addr[ADDR_W-2:0], si_s};
                if (eng_q.bitcnt == 3'd7) begin
                    case (eng_q.st)
                        S_CMD: begin
                            eng_d.st = S_IGNORE;
                            if (!busy || op == OP_RDSR) begin
                                case (op)
                                    OP_WREN:  eng_d.wel = 1'b1;
                                    OP_WRDI:  eng_d.wel = 1'b0;
                                    OP_RDSR:  begin eng_d.st = S_ST_RD; eng_d.load = 1'b1; end
                                    OP_WRSR:  if (eng_q.wel) eng_d.st = S_ST_WR;
                                    OP_READ:  begin eng_d.st = S_ADDR_HI; eng_d.is_wr = 1'b0; end
                                    OP_WRITE: if (eng_q.wel) begin
                                        eng_d.st    = S_ADDR_HI;
                                        eng_d.is_wr = 1'b1;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                        S_ADDR_HI: eng_d.st = S_ADDR_LO;
                        S_ADDR_LO: begin
                            if (eng_q.is_wr) begin
                                eng_d.st = S_WR_DATA;
                            end else begin
                                eng_d.st   = S_RD_DATA;
                                eng_d.load = 1'b1;
                            end
                        end
                        S_RD_DATA, S_ST_RD: eng_d.load = 1'b1;
                        S_WR_DATA: if (eng_q.pend == PEND_NONE) begin
                            eng_d.pend      = PEND_ARRAY;
                            eng_d.pend_data = byte_in;
                        end
                        S_ST_WR: if (eng_q.pend == PEND_NONE) begin
                            eng_d.pend      = PEND_STATUS;
                            eng_d.pend_data = byte_in;
                        end
                        default: ;
                    endcase
                end
            end

            if (!eng_q.paused && sck_fall && (eng_q.st == S_RD_DATA || eng_q.st == S_ST_RD)) begin
                eng_d.so     = eng_q.out_sh[7];
                eng_d.out_sh = {eng_q.out_sh[6:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q        <= '0;
            eng_q.cs_p   <= 1'b1;
            eng_q.hold_p <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign so_o    = eng_q.so;
    assign so_oe_o = ~cs_s & ~eng_q.paused & (eng_q.st == S_RD_DATA || eng_q.st == S_ST_RD);
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic cs_rise,
    input logic sck_fall,
    input logic paused,
    input logic busy,
    input logic wel,
    input logic mem_we,
    input logic so_o,
    input logic so_oe_o
);
    p_deselect_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe_o);

    p_pause_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !so_oe_o);

    p_commit_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cs_s && !$past(cs_s)));

    p_commit_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    p_busy_from_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    p_wel_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    p_so_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_o) |-> $past(sck_fall));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .cs_rise (cs_rise),
    .sck_fall(sck_fall),
    .paused  (paused),
    .busy    (busy),
    .wel     (wel),
    .mem_we  (mem_we),
    .so_o    (so_o),
    .so_oe_o (so_oe_o)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    localparam int BUSY = 1500;
    localparam int H    = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    logic mode3 = 1'b0;
    int   n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    spi_mem_slave #(.ADDR_W(11), .BUSY_CYC(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck),
        .si_i(si), .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe)
    );

    // {opcode, expected status afterwards}
    localparam logic [15:0] VEC [8] = '{
        16'h0602, 16'h0400, 16'h0E02, 16'h0C00,
        16'h0E02, 16'h1602, 16'h8C02, 16'h0400
    };

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_seen);
        rx = '0;
        oe_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            wait_clk(H);
            rx[i] = so;
            if (so_oe) oe_seen = 1'b1;
            sck = 1'b1;
            wait_clk(H);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic desel();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        logic o;
        xfer(b, r, o);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel(); send(op); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic o;
        sel(); send(8'h05); xfer(8'h00, s, o); desel();
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
        cmd1(8'h06);
        sel(); send(8'h02); send(a[15:8]); send(a[7:0]); send(d); desel();
        wait_clk(BUSY + 50);
    endtask

    task automatic rd_first(input logic [15:0] a);
        sel(); send(8'h03); send(a[15:8]); send(a[7:0]);
    endtask

    initial begin
        logic [7:0] s, r;
        logic o;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);

        check(so_oe == 1'b0, "R1 oe after reset", {7'd0, so_oe}, 8'h00);
        rdsr(s);
        check(s == 8'h00, "R1 status after reset", s, 8'h00);

        for (int k = 0; k < 8; k++) begin
            cmd1(VEC[k][15:8]);
            rdsr(s);
            if ((VEC[k][15:8] & 8'hF7) == 8'h04)
                check(s == VEC[k][7:0], "R11 disable latch", s, VEC[k][7:0]);
            else
                check(s == VEC[k][7:0], "R2 opcode decode", s, VEC[k][7:0]);
        end

        // R10: busy window after a write
        cmd1(8'h06);
        sel(); send(8'h02); send(8'h07); send(8'hFF); send(8'h5A); desel();
        rdsr(s);
        check(s == 8'hFF, "R10 status during busy", s, 8'hFF);
        rd_first(16'h0000); xfer(8'h00, r, o); desel();
        check(o == 1'b0, "R10 read refused while busy", {7'd0, o}, 8'h00);
        wait_clk(BUSY + 50);
        rdsr(s);
        check(s == 8'h00, "R10 latch cleared after busy", s, 8'h00);

        wr_byte(16'h0001, 8'h3C);
        // R5: second data byte ignored
        cmd1(8'h06);
        sel(); send(8'h02); send(8'h00); send(8'h00); send(8'hC3); send(8'h99); desel();
        wait_clk(BUSY + 50);

        // R4: wrap from top address to zero
        rd_first(16'h07FF);
        xfer(8'h00, r, o); check(r == 8'h5A, "R4 top byte", r, 8'h5A);
        check(o == 1'b1, "R8 oe while reading", {7'd0, o}, 8'h01);
        xfer(8'h00, r, o); check(r == 8'hC3, "R4 wrap to zero", r, 8'hC3);
        xfer(8'h00, r, o); check(r == 8'h3C, "R5 only first byte stored", r, 8'h3C);
        desel();
        check(so_oe == 1'b0, "R8 oe after deselect", {7'd0, so_oe}, 8'h00);

        // R4: upper address bits ignored
        wr_byte(16'hF805, 8'h77);
        rd_first(16'h0005); xfer(8'h00, r, o); desel();
        check(r == 8'h77, "R4 upper bits ignored", r, 8'h77);

        // R6: programming without the latch
        sel(); send(8'h02); send(8'h00); send(8'h05); send(8'h11); desel();
        sel(); send(8'h01); send(8'hFF); desel();
        rdsr(s);
        check(s == 8'h00, "R6 no busy or status change", s, 8'h00);
        rd_first(16'h0005); xfer(8'h00, r, o); desel();
        check(r == 8'h77, "R6 array unchanged", r, 8'h77);

        // R5: released before the data byte
        cmd1(8'h06);
        sel(); send(8'h02); send(8'h00); send(8'h05); desel();
        rdsr(s);
        check(s == 8'h02, "R5 incomplete write starts nothing", s, 8'h02);
        rd_first(16'h0005); xfer(8'h00, r, o); desel();
        check(r == 8'h77, "R5 incomplete write stores nothing", r, 8'h77);
        cmd1(8'h04);

        // R7: invalid opcode
        sel(); send(8'h83); xfer(8'h00, r, o);
        check(o == 1'b0, "R7 oe off after invalid opcode", {7'd0, o}, 8'h00);
        xfer(8'h00, r, o);
        check(o == 1'b0, "R7 stays off", {7'd0, o}, 8'h00);
        desel();
        rd_first(16'h0005); xfer(8'h00, r, o); desel();
        check(r == 8'h77 && o, "R7 next selection decodes", r, 8'h77);

        // R9: pause mid-stream
        rd_first(16'h07FF);
        hold_n = 1'b0;
        wait_clk(2 * H);
        check(so_oe == 1'b0, "R9 oe off while paused", {7'd0, so_oe}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            si = i[0]; sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
        end
        hold_n = 1'b1;
        wait_clk(H);
        xfer(8'h00, r, o); check(r == 8'h5A, "R9 resume first byte", r, 8'h5A);
        xfer(8'h00, r, o); check(r == 8'hC3, "R9 resume second byte", r, 8'hC3);
        desel();

        // R12: status write masks bits
        cmd1(8'h06);
        sel(); send(8'h01); send(8'hFF); desel();
        rdsr(s);
        check(s == 8'hFF, "R12 busy after status write", s, 8'hFF);
        wait_clk(BUSY + 50);
        rdsr(s);
        check(s == 8'h8C, "R12 stored bits only", s, 8'h8C);
        cmd1(8'h06);
        sel(); send(8'h01); send(8'h00); desel();
        wait_clk(BUSY + 50);
        rdsr(s);
        check(s == 8'h00, "R12 status cleared", s, 8'h00);

        // R3: clock idle high framing
        mode3 = 1'b1; sck = 1'b1; wait_clk(H);
        rd_first(16'h0005); xfer(8'h00, r, o); desel();
        check(r == 8'h77, "R3 idle-high read", r, 8'h77);
        rdsr(s);
        check(s == 8'h00, "R3 idle-high status", s, 8'h00);
        mode3 = 1'b0; sck = 1'b0; wait_clk(H);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_clk(190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule